// File: doc/BRIEF.md
# Chained DMA Tag Sequencer

This block walks the tag chain of a single DMA channel that fetches its source data by following tags in memory. For every tag the surrounding fetch logic presents, the block works out the next data address and the next tag address in one clock. It updates a two-entry call/return address stack and reports whether the chain has finished. The tag is the 3-bit kind, its address field and its quadword count. Reading tags from memory and moving the data belong to the neighbouring logic.

The channel's 32-bit control word lives in the block. A write to it follows a merge rule that keeps the stored upper half when a chained-mode write arrives with an empty upper half. Bits 5:4 of the control word hold the stack depth. The block takes tags only while the channel is started.

Tags arrive on a valid/ready stream. A tag transfers in a cycle where both `tag_valid` and `tag_ready` are high. While `tag_ready` is low, the source holds the tag and the block leaves it alone. The result comes out as a one-cycle `res_valid` pulse. It has no back-pressure, so the consumer must take it in that cycle.

Top module: `dmatag_seq`

## Requirements
- R1: After reset, the data address, tag address, both stack entries and the control word are zero, and `res_valid`, `done` and `stack_ovf` are low.
- R2: `tag_ready` is high only when control bit 8 is set, `glb_en` is high, and neither `ctl_wr_en` nor `tadr_ld_en` is high. A tag offered while `tag_ready` is low produces no result and changes no state.
- R3: A control write stores the whole word, except in one case. If write bits 3:2 are 01 and write bits 31:16 are zero, the stored bits 31:16 are kept and only bits 15:0 are replaced.
- R4: Tag kind 0 (addressed, final) sets the data address to the tag address field, keeps the tag address and ends the chain.
- R5: Tag kind 1 (count) sets the data address to tag address + 16 and the tag address to the new data address + 16 × count. The chain continues.
- R6: Tag kind 2 (jump) sets the data address to tag address + 16 and the tag address to the address field. The chain continues.
- R7: Tag kinds 3 and 4 (addressed) set the data address to the address field and advance the tag address by 16. The chain continues.
- R8: Tag kind 5 (call) at depth 0 pushes tag address + 16 + 16 × count into stack entry 0 and sets depth to 01. At depth 1 it pushes the same value into entry 1 and sets depth to 10. In both cases the data address becomes tag address + 16 and the tag address becomes the address field.
- R9: A call at depth 10 or 11 ends the chain with `stack_ovf` high and changes no address, stack entry or depth.
- R10: Tag kind 6 (return) sets the data address to tag address + 16. At depth 10 it loads the tag address from entry 1, clears entry 1 and sets depth to 01. At depth 01 it does the same with entry 0 and sets depth to 00.
- R11: A return at depth 00 or 11 sets the data address to tag address + 16, keeps the tag address and stack, and ends the chain.
- R12: Tag kind 7 (final) sets the data address to tag address + 16, keeps the tag address and ends the chain.
- R13: An accepted tag gives exactly one `res_valid` cycle, in the cycle after acceptance. `done` and `stack_ovf` are high only during `res_valid`, and the updated registers appear in that same cycle.
- R14: A cycle with `tadr_ld_en` high loads `tadr_ld_data` into the tag address. The loaded value is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global DMA enable |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 32 | Control word write data |
| tadr_ld_en | input | 1 | Tag address load strobe |
| tadr_ld_data | input | ADDR_W | Tag address load value |
| tag_valid | input | 1 | Tag offered |
| tag_ready | output | 1 | Block can take a tag |
| tag_id | input | 3 | Tag kind |
| tag_addr | input | ADDR_W | Tag address field |
| tag_qwc | input | QWC_W | Tag quadword count |
| res_valid | output | 1 | One-cycle result pulse |
| done | output | 1 | Chain ended with this tag |
| stack_ovf | output | 1 | Call refused, stack full |
| madr_o | output | ADDR_W | Data address |
| tadr_o | output | ADDR_W | Tag address |
| asr0_o | output | ADDR_W | Stack entry 0 |
| asr1_o | output | ADDR_W | Stack entry 1 |
| depth_o | output | 2 | Stack depth (control bits 5:4) |
| ctl_o | output | 32 | Control word |

## Verification
The bench uses the default 32-bit addresses and 16-bit counts. With these widths a count can move the next tag up to about one megabyte past the current one, and random tag addresses near the top of the space exercise the modulo-2^32 wrap of every sum. Random control writes put arbitrary depths into bits 5:4, including the illegal 11. The random mix of calls and returns then pushes and pops from every stack state, and directed sequences cover a full stack, an overflowing call and a return from an empty stack.

// File: rtl/dmatag_pkg.sv
package dmatag_pkg;
  typedef enum logic [2:0] {
    TAG_REFE = 3'd0,
    TAG_CNT  = 3'd1,
    TAG_NEXT = 3'd2,
    TAG_REF  = 3'd3,
    TAG_REFS = 3'd4,
    TAG_CALL = 3'd5,
    TAG_RET  = 3'd6,
    TAG_END  = 3'd7
  } tag_kind_t;

  localparam int unsigned CTL_W      = 32;
  localparam int unsigned CTL_HALF   = CTL_W / 2;
  localparam int unsigned DEPTH_LSB  = 4;
  localparam int unsigned START_BIT  = 8;
  localparam int unsigned MODE_LSB   = 2;
  localparam logic [1:0]  MODE_CHAIN = 2'b01;
endpackage

// File: rtl/dmatag_ctlmerge.sv
module dmatag_ctlmerge
  import dmatag_pkg::*;
(
  input  logic [CTL_W-1:0] old_ctl,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] new_ctl
);
  logic keep_upper;

  always_comb begin
    keep_upper = (wr_data[MODE_LSB +: 2] == MODE_CHAIN) &&
                 (wr_data[CTL_W-1:CTL_HALF] == '0);
    if (keep_upper) new_ctl = {old_ctl[CTL_W-1:CTL_HALF], wr_data[CTL_HALF-1:0]};
    else            new_ctl = wr_data;
  end
endmodule

// File: rtl/dmatag_step.sv
module dmatag_step
  import dmatag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned QWC_W  = 16
) (
  input  tag_kind_t          kind,
  input  logic [ADDR_W-1:0]  addr_fld,
  input  logic [QWC_W-1:0]   qwc,
  input  logic [ADDR_W-1:0]  cur_madr,
  input  logic [ADDR_W-1:0]  cur_tadr,
  input  logic [ADDR_W-1:0]  cur_asr0,
  input  logic [ADDR_W-1:0]  cur_asr1,
  input  logic [1:0]         cur_depth,
  output logic [ADDR_W-1:0]  nxt_madr,
  output logic [ADDR_W-1:0]  nxt_tadr,
  output logic [ADDR_W-1:0]  nxt_asr0,
  output logic [ADDR_W-1:0]  nxt_asr1,
  output logic [1:0]         nxt_depth,
  output logic               ends,
  output logic               ovf
);
  localparam int unsigned       QW_SHIFT = 4;
  localparam logic [ADDR_W-1:0] QW_BYTES = ADDR_W'(1) << QW_SHIFT;

  logic [ADDR_W-1:0] after_tag;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] ret_point;

  assign after_tag = cur_tadr + QW_BYTES;
  assign span      = ADDR_W'(qwc) << QW_SHIFT;
  assign ret_point = after_tag + span;

  always_comb begin
    nxt_madr  = cur_madr;
    nxt_tadr  = cur_tadr;
    nxt_asr0  = cur_asr0;
    nxt_asr1  = cur_asr1;
    nxt_depth = cur_depth;
    ends      = 1'b0;
    ovf       = 1'b0;
    unique case (kind)
      TAG_REFE: begin
        nxt_madr = addr_fld;
        ends     = 1'b1;
      end
      TAG_CNT: begin
        nxt_madr = after_tag;
        nxt_tadr = ret_point;
      end
      TAG_NEXT: begin
        nxt_madr = after_tag;
        nxt_tadr = addr_fld;
      end
      TAG_REF, TAG_REFS: begin
        nxt_madr = addr_fld;
        nxt_tadr = after_tag;
      end
      TAG_CALL: begin
        if (cur_depth == 2'b00) begin
          nxt_asr0  = ret_point;
          nxt_depth = 2'b01;
          nxt_madr  = after_tag;
          nxt_tadr  = addr_fld;
        end else if (cur_depth == 2'b01) begin
          nxt_asr1  = ret_point;
          nxt_depth = 2'b10;
          nxt_madr  = after_tag;
          nxt_tadr  = addr_fld;
        end else begin
          ends = 1'b1;
          ovf  = 1'b1;
        end
      end
      TAG_RET: begin
        nxt_madr = after_tag;
        if (cur_depth == 2'b10) begin
          nxt_tadr  = cur_asr1;
          nxt_asr1  = '0;
          nxt_depth = 2'b01;
        end else if (cur_depth == 2'b01) begin
          nxt_tadr  = cur_asr0;
          nxt_asr0  = '0;
          nxt_depth = 2'b00;
        end else begin
          ends = 1'b1;
        end
      end
      TAG_END: begin
        nxt_madr = after_tag;
        ends     = 1'b1;
      end
      default: ends = 1'b1;
    endcase
  end
endmodule

// File: rtl/dmatag_seq.sv
module dmatag_seq
  import dmatag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned QWC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              ctl_wr_en,
  input  logic [31:0]       ctl_wr_data,
  input  logic              tadr_ld_en,
  input  logic [ADDR_W-1:0] tadr_ld_data,
  input  logic              tag_valid,
  output logic              tag_ready,
  input  logic [2:0]        tag_id,
  input  logic [ADDR_W-1:0] tag_addr,
  input  logic [QWC_W-1:0]  tag_qwc,
  output logic              res_valid,
  output logic              done,
  output logic              stack_ovf,
  output logic [ADDR_W-1:0] madr_o,
  output logic [ADDR_W-1:0] tadr_o,
  output logic [ADDR_W-1:0] asr0_o,
  output logic [ADDR_W-1:0] asr1_o,
  output logic [1:0]        depth_o,
  output logic [31:0]       ctl_o
);
  logic [CTL_W-1:0]  ctl_q, ctl_merged;
  logic [ADDR_W-1:0] madr_q, tadr_q, asr0_q, asr1_q;
  logic [ADDR_W-1:0] madr_n, tadr_n, asr0_n, asr1_n;
  logic [1:0]        depth_n;
  logic              step_end, step_ovf, accept;
  logic              res_q, done_q, ovf_q;

  assign tag_ready = ctl_q[START_BIT] & glb_en & ~ctl_wr_en & ~tadr_ld_en;
  assign accept    = tag_valid & tag_ready;

  dmatag_ctlmerge u_merge (
    .old_ctl (ctl_q),
    .wr_data (ctl_wr_data),
    .new_ctl (ctl_merged)
  );

  dmatag_step #(.ADDR_W(ADDR_W), .QWC_W(QWC_W)) u_step (
    .kind      (tag_kind_t'(tag_id)),
    .addr_fld  (tag_addr),
    .qwc       (tag_qwc),
    .cur_madr  (madr_q),
    .cur_tadr  (tadr_q),
    .cur_asr0  (asr0_q),
    .cur_asr1  (asr1_q),
    .cur_depth (ctl_q[DEPTH_LSB +: 2]),
    .nxt_madr  (madr_n),
    .nxt_tadr  (tadr_n),
    .nxt_asr0  (asr0_n),
    .nxt_asr1  (asr1_n),
    .nxt_depth (depth_n),
    .ends      (step_end),
    .ovf       (step_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      madr_q <= '0;
      tadr_q <= '0;
      asr0_q <= '0;
      asr1_q <= '0;
    end else if (ctl_wr_en) begin
      ctl_q <= ctl_merged;
      if (tadr_ld_en) tadr_q <= tadr_ld_data;
    end else if (tadr_ld_en) begin
      tadr_q <= tadr_ld_data;
    end else if (accept) begin
      madr_q                 <= madr_n;
      tadr_q                 <= tadr_n;
      asr0_q                 <= asr0_n;
      asr1_q                 <= asr1_n;
      ctl_q[DEPTH_LSB +: 2]  <= depth_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      res_q  <= accept;
      done_q <= accept & step_end;
      ovf_q  <= accept & step_ovf;
    end
  end

  assign res_valid = res_q;
  assign done      = done_q;
  assign stack_ovf = ovf_q;
  assign madr_o    = madr_q;
  assign tadr_o    = tadr_q;
  assign asr0_o    = asr0_q;
  assign asr1_o    = asr1_q;
  assign depth_o   = ctl_q[DEPTH_LSB +: 2];
  assign ctl_o     = ctl_q;
endmodule

// File: rtl/dmatag_seq_chk.sv
module dmatag_seq_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned QWC_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glb_en,
  input logic              tag_valid,
  input logic              tag_ready,
  input logic [2:0]        tag_id,
  input logic [QWC_W-1:0]  tag_qwc,
  input logic              res_valid,
  input logic              done,
  input logic              stack_ovf,
  input logic [ADDR_W-1:0] tadr_o,
  input logic [ADDR_W-1:0] asr0_o,
  input logic [1:0]        depth_o,
  input logic [31:0]       ctl_o
);
  logic acc;
  assign acc = tag_valid && tag_ready;

  AST_READY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_o[8] || !glb_en) |-> !tag_ready); // R2
  AST_REFE_HOLDS_TADR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && tag_id == 3'd0) |=> (done && $stable(tadr_o))); // R4
  AST_CALL_FIRST_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && tag_id == 3'd5 && depth_o == 2'b00) |=>
      (depth_o == 2'b01 && asr0_o == $past(tadr_o + 32'd16 + (ADDR_W'(tag_qwc) << 4)))); // R8
  AST_CALL_FULL_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && tag_id == 3'd5 && depth_o[1]) |=> (stack_ovf && done && $stable(tadr_o))); // R9
  AST_RET_EMPTY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && tag_id == 3'd6 && depth_o == 2'b00) |=> (done && $stable(tadr_o))); // R11
  AST_END_HOLDS_TADR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && tag_id == 3'd7) |=> (done && $stable(tadr_o))); // R12
  AST_RESULT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid); // R13
  AST_NO_RESULT_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !res_valid); // R13
  AST_FLAGS_INSIDE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done || stack_ovf) |-> res_valid); // R13
endmodule

bind dmatag_seq dmatag_seq_chk #(.ADDR_W(ADDR_W), .QWC_W(QWC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en    (glb_en),
  .tag_valid (tag_valid),
  .tag_ready (tag_ready),
  .tag_id    (tag_id),
  .tag_qwc   (tag_qwc),
  .res_valid (res_valid),
  .done      (done),
  .stack_ovf (stack_ovf),
  .tadr_o    (tadr_o),
  .asr0_o    (asr0_o),
  .depth_o   (depth_o),
  .ctl_o     (ctl_o)
);

// File: tb/dmatag_seq_tb.sv
`timescale 1ns/1ps
module dmatag_seq_tb_top;
  localparam int unsigned AW = 32;
  localparam int unsigned QW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          glb_en = 1'b0;
  logic          ctl_wr_en = 1'b0;
  logic [31:0]   ctl_wr_data = '0;
  logic          tadr_ld_en = 1'b0;
  logic [AW-1:0] tadr_ld_data = '0;
  logic          tag_valid = 1'b0;
  logic          tag_ready;
  logic [2:0]    tag_id = '0;
  logic [AW-1:0] tag_addr = '0;
  logic [QW-1:0] tag_qwc = '0;
  logic          res_valid, done, stack_ovf;
  logic [AW-1:0] madr_o, tadr_o, asr0_o, asr1_o;
  logic [1:0]    depth_o;
  logic [31:0]   ctl_o;

  always #2 clk = ~clk;

  dmatag_seq #(.ADDR_W(AW), .QWC_W(QW)) dut_i (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .tadr_ld_en(tadr_ld_en), .tadr_ld_data(tadr_ld_data),
    .tag_valid(tag_valid), .tag_ready(tag_ready), .tag_id(tag_id),
    .tag_addr(tag_addr), .tag_qwc(tag_qwc),
    .res_valid(res_valid), .done(done), .stack_ovf(stack_ovf),
    .madr_o(madr_o), .tadr_o(tadr_o), .asr0_o(asr0_o), .asr1_o(asr1_o),
    .depth_o(depth_o), .ctl_o(ctl_o)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] m_ctl, m_madr, m_tadr, m_asr0, m_asr1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge_ctl(logic [31:0] old, logic [31:0] wd);
    if (wd[3:2] == 2'b01 && wd[31:16] == 16'h0) return {old[31:16], wd[15:0]};
    return wd;
  endfunction

  function automatic string req_of(logic [2:0] id, logic [1:0] dep);
    case (id)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3, 3'd4: return "R7";
      3'd5: return (dep < 2) ? "R8" : "R9";
      3'd6: return (dep == 2'b01 || dep == 2'b10) ? "R10" : "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check_state(string req);
    chk(req, madr_o, m_madr);
    chk(req, tadr_o, m_tadr);
    chk(req, asr0_o, m_asr0);
    chk(req, asr1_o, m_asr1);
    chk(req, ctl_o, m_ctl);
  endtask

  task automatic wr_ctl(logic [31:0] d);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_data = d;
    #1 chk("R2", 32'(tag_ready), 32'd0);
    @(negedge clk);
    ctl_wr_en = 1'b0;
    m_ctl = merge_ctl(m_ctl, d);
    chk("R3", ctl_o, m_ctl);
  endtask

  task automatic ld_tadr(logic [31:0] a);
    @(negedge clk);
    tadr_ld_en = 1'b1; tadr_ld_data = a;
    @(negedge clk);
    tadr_ld_en = 1'b0;
    m_tadr = a;
    chk("R14", tadr_o, m_tadr);
  endtask

  task automatic send_tag(logic [2:0] id, logic [31:0] a, logic [15:0] q);
    logic [1:0]  dep;
    logic [31:0] aft, rp;
    logic        e_done, e_ovf;
    string       req;
    dep = m_ctl[5:4];
    req = req_of(id, dep);
    aft = m_tadr + 32'd16;
    rp  = aft + ({16'h0, q} << 4);
    e_done = 1'b0; e_ovf = 1'b0;
    case (id)
      3'd0: begin m_madr = a; e_done = 1'b1; end
      3'd1: begin m_madr = aft; m_tadr = rp; end
      3'd2: begin m_madr = aft; m_tadr = a; end
      3'd3, 3'd4: begin m_madr = a; m_tadr = aft; end
      3'd5: begin
        if (dep == 2'b00) begin m_asr0 = rp; m_ctl[5:4] = 2'b01; m_madr = aft; m_tadr = a; end
        else if (dep == 2'b01) begin m_asr1 = rp; m_ctl[5:4] = 2'b10; m_madr = aft; m_tadr = a; end
        else begin e_done = 1'b1; e_ovf = 1'b1; end
      end
      3'd6: begin
        m_madr = aft;
        if (dep == 2'b10) begin m_tadr = m_asr1; m_asr1 = '0; m_ctl[5:4] = 2'b01; end
        else if (dep == 2'b01) begin m_tadr = m_asr0; m_asr0 = '0; m_ctl[5:4] = 2'b00; end
        else e_done = 1'b1;
      end
      default: begin m_madr = aft; e_done = 1'b1; end
    endcase
    @(negedge clk);
    tag_valid = 1'b1; tag_id = id; tag_addr = a; tag_qwc = q;
    #1 chk("R2", 32'(tag_ready), 32'd1);
    @(negedge clk);
    tag_valid = 1'b0;
    chk("R13", 32'(res_valid), 32'd1);
    chk(req, 32'(done), 32'(e_done));
    chk(req, 32'(stack_ovf), 32'(e_ovf));
    check_state(req);
    @(negedge clk);
    chk("R13", 32'(res_valid), 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    m_ctl = '0; m_madr = '0; m_tadr = '0; m_asr0 = '0; m_asr1 = '0;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");
    chk("R1", 32'(res_valid), 32'd0);
    chk("R1", 32'(done | stack_ovf), 32'd0);
    chk("R2", 32'(tag_ready), 32'd0);

    // R3 merge rule
    wr_ctl(32'hABCD_0100);
    wr_ctl(32'h0000_0104);
    wr_ctl(32'h0000_0108);
    wr_ctl(32'h0001_0104);
    wr_ctl(32'h0000_0100);

    // R2: glb_en low blocks tags
    @(negedge clk);
    tag_valid = 1'b1; tag_id = 3'd1; tag_addr = 32'h55; tag_qwc = 16'd3;
    #1 chk("R2", 32'(tag_ready), 32'd0);
    @(negedge clk);
    tag_valid = 1'b0;
    chk("R2", 32'(res_valid), 32'd0);
    check_state("R2");
    glb_en = 1'b1;

    ld_tadr(32'h0000_1000);
    // stack fill, overflow, drain, empty return
    send_tag(3'd5, 32'h2000, 16'd2);
    send_tag(3'd5, 32'h3000, 16'd1);
    send_tag(3'd5, 32'h4000, 16'd7);
    send_tag(3'd6, 32'h0, 16'd0);
    send_tag(3'd6, 32'h0, 16'd0);
    send_tag(3'd6, 32'h0, 16'd0);
    // each kind once
    send_tag(3'd1, 32'h0, 16'hFFFF);
    send_tag(3'd2, 32'h8000, 16'd4);
    send_tag(3'd3, 32'h9100, 16'd4);
    send_tag(3'd4, 32'h9200, 16'd4);
    send_tag(3'd0, 32'hA000, 16'd1);
    send_tag(3'd7, 32'hB000, 16'd1);
    // wrap at top of address space
    ld_tadr(32'hFFFF_FFF0);
    send_tag(3'd1, 32'h0, 16'd2);
    // illegal depth 11
    wr_ctl(32'h0000_0130);
    send_tag(3'd5, 32'hC000, 16'd1);
    send_tag(3'd6, 32'h0, 16'd0);
    wr_ctl(32'h0000_0100);

    for (int i = 0; i < 800; i++) begin
      int unsigned r;
      r = $urandom_range(0, 31);
      if (r == 0) wr_ctl(($urandom() & 32'hFFFF_FEFF) | 32'h0000_0100);
      else if (r == 1) ld_tadr($urandom());
      else send_tag(3'($urandom_range(0, 7)), $urandom(), 16'($urandom()));
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule